// File: doc/BRIEF.md
# Two-Path Prioritized Interrupt Arbiter

This block picks one winning request out of a set of interrupt lines grouped into banks (three banks of 32 lines by default). It runs two independent selection paths. The normal path serves lines whose fast-select bit is clear, and the fast path serves lines whose fast-select bit is set. For each path the block filters the lines down to the eligible ones and compares their priority values in a registered binary tree. It then latches the winning line number and raises that path's interrupt output.

Each path holds a one-shot agreement token. An output rises only when three things hold: the token is armed, some line is eligible, and the global mask does not block. When the output rises, the token is consumed and the winning number is frozen. Software re-arms a path by writing its agreement bit in the control word. That write drops the output, and the path then competes again with the current inputs. Capturing edges or levels on the raw request lines and the register file that stores mask, fast-select and priority lie outside this block. They reach it as plain vectors.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line is eligible for the normal path when its pending bit is 1, its mask bit is 0 and its fast-select bit is 0. A masked line never wins.
- R2: A line is eligible for the fast path when its pending bit is 1, its mask bit is 0 and its fast-select bit is 1. Such a line never wins on the normal path.
- R3: Among eligible lines the smallest priority value wins, and 0 is the most urgent. Line i's priority is `prioFlat[i*PRIO_W +: PRIO_W]`.
- R4: When several eligible lines share the best priority value, the line with the highest index wins.
- R5: The reported code is 32 times the bank number plus the bit position within the bank. Line i is bit i of the flat vectors, so the code equals the flat index (for example, bank 1 bit 8 gives 40, and bank 2 bit 31 gives 95).
- R6: A path's output rises at the second rising clock edge after its inputs are presented, provided its token is armed, a line is eligible and the global mask is clear. At that same edge the token is cleared and the winning code is latched.
- R7: Once a path's output is high, it stays high and its code stays unchanged until that path's agreement bit is written, whatever the request inputs do.
- R8: A control write (`ctrlWrEn` = 1) with bit 0 set is the normal-path agreement, and one with bit 1 set is the fast-path agreement. At the write edge the agreement drops that output and re-arms its token. If a line is still eligible, the output rises again at the next edge with the new winner. A 0 in an agreement bit leaves that path untouched, and an agreement takes precedence over a firing in the same cycle.
- R9: Control bit 2 is the global mask. It is loaded on every control write, and while it is 1 no output may rise. Clearing it lets an armed path with an eligible line fire at the next edge.
- R10: After reset both outputs are low, both codes are 0, both tokens are armed and the global mask is clear.
- R11: The two paths are independent. Firing or agreeing on one path changes neither the output nor the code of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pendVec | input | NUM_BANKS*LINES_PER_BANK | Pending request per line |
| maskVec | input | NUM_BANKS*LINES_PER_BANK | 1 blocks the line |
| fastSel | input | NUM_BANKS*LINES_PER_BANK | 1 routes the line to the fast path |
| prioFlat | input | NUM_BANKS*LINES_PER_BANK*PRIO_W | Packed per-line priority values |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 3 | bit0 normal agreement, bit1 fast agreement, bit2 global mask |
| normIrq | output | 1 | Normal-path interrupt output |
| fastIrq | output | 1 | Fast-path interrupt output |
| normCode | output | $clog2(NUM_BANKS*LINES_PER_BANK) | Latched normal-path winning line |
| fastCode | output | $clog2(NUM_BANKS*LINES_PER_BANK) | Latched fast-path winning line |

## Verification
The bench builds the block with its defaults: three banks of 32 lines and 5-bit priorities. This puts codes that cross bank boundaries within reach, including the top line 95. With 96 lines the tree pads out to 128 leaves, so the bench also checks that the unused padded leaves never win. Priorities 0 and 31 cover both ends of the compare range. Directed scenarios cover ties spread across all three banks, a winner that stays frozen while requests change, re-arming with a new winner, and the global mask holding back an armed path.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Strobes from control to datapath: freeze the current winner of a path.
  typedef struct packed {
    logic latchFast;
    logic latchNorm;
  } arbStrobe_t;
endpackage

// File: rtl/prio_irq_tree.sv
module prio_irq_tree #(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 5,
  parameter int CODE_W    = 7
) (
  input  logic [NUM_LINES-1:0]        elig,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  output logic                        rootValid,
  output logic [CODE_W-1:0]           rootIdx
);
  localparam int LEVELS = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic              nodeValid [NODES];
  logic [PRIO_W-1:0] nodePrio  [NODES];
  logic [CODE_W-1:0] nodeIdx   [NODES];

  // Leaves sit at the tail of a heap-ordered array, lowest line leftmost.
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_LINES) begin : g_real
      assign nodeValid[LEAVES-1+i] = elig[i];
      assign nodePrio[LEAVES-1+i]  = prioFlat[i*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nodeValid[LEAVES-1+i] = 1'b0;
      assign nodePrio[LEAVES-1+i]  = '1;
    end
    assign nodeIdx[LEAVES-1+i] = CODE_W'(i);
  end

  // Each node keeps the better child; the upper (higher-index) child wins ties.
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic takeHi;
    assign takeHi = nodeValid[2*n+2] &&
                    (!nodeValid[2*n+1] || (nodePrio[2*n+2] <= nodePrio[2*n+1]));
    assign nodeValid[n] = nodeValid[2*n+1] | nodeValid[2*n+2];
    assign nodePrio[n]  = takeHi ? nodePrio[2*n+2] : nodePrio[2*n+1];
    assign nodeIdx[n]   = takeHi ? nodeIdx[2*n+2]  : nodeIdx[2*n+1];
  end

  assign rootValid = nodeValid[0];
  assign rootIdx   = nodeIdx[0];
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 5,
  parameter int CODE_W    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        pendVec,
  input  logic [NUM_LINES-1:0]        maskVec,
  input  logic [NUM_LINES-1:0]        fastSel,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  input  arbStrobe_t                  strobe,
  output logic                        normAvail,
  output logic                        fastAvail,
  output logic [CODE_W-1:0]           normCode,
  output logic [CODE_W-1:0]           fastCode
);
  localparam int NUM_PATHS = 2;

  logic [NUM_LINES-1:0] eligPath  [NUM_PATHS];
  logic                 treeValid [NUM_PATHS];
  logic [CODE_W-1:0]    treeIdx   [NUM_PATHS];
  logic                 bestValidQ[NUM_PATHS];
  logic [CODE_W-1:0]    bestIdxQ  [NUM_PATHS];
  logic [CODE_W-1:0]    codeQ     [NUM_PATHS];
  logic [NUM_PATHS-1:0] latchBits;

  assign eligPath[0] = pendVec & ~maskVec & ~fastSel;
  assign eligPath[1] = pendVec & ~maskVec &  fastSel;
  assign latchBits   = {strobe.latchFast, strobe.latchNorm};

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    prio_irq_tree #(
      .NUM_LINES(NUM_LINES),
      .PRIO_W   (PRIO_W),
      .CODE_W   (CODE_W)
    ) u_tree (
      .elig     (eligPath[p]),
      .prioFlat (prioFlat),
      .rootValid(treeValid[p]),
      .rootIdx  (treeIdx[p])
    );

    // Compare-tree result registered every cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bestValidQ[p] <= 1'b0;
        bestIdxQ[p]   <= '0;
      end else begin
        bestValidQ[p] <= treeValid[p];
        bestIdxQ[p]   <= treeIdx[p];
      end
    end

    // Winner frozen only on a control strobe.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) codeQ[p] <= '0;
      else if (latchBits[p]) codeQ[p] <= bestIdxQ[p];
    end

    // R1/R2: the tree never reports a line the eligibility filter rejected.
    assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      treeValid[p] |-> eligPath[p][treeIdx[p]]);

    // R7: the latched code moves only when control asks for it.
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !latchBits[p] |=> $stable(codeQ[p]));
  end

  assign normAvail = bestValidQ[0];
  assign fastAvail = bestValidQ[1];
  assign normCode  = codeQ[0];
  assign fastCode  = codeQ[1];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlWrEn,
  input  logic [2:0] ctrlWrData,
  input  logic       normAvail,
  input  logic       fastAvail,
  output arbStrobe_t strobe,
  output logic       normIrq,
  output logic       fastIrq
);
  localparam int NUM_PATHS = 2;
  localparam int GMASK_BIT = 2;

  logic                 gmaskQ;
  logic [NUM_PATHS-1:0] tokQ;
  logic [NUM_PATHS-1:0] irqQ;
  logic [NUM_PATHS-1:0] avail;
  logic [NUM_PATHS-1:0] agree;
  logic [NUM_PATHS-1:0] fire;

  assign avail = {fastAvail, normAvail};
  assign agree = {NUM_PATHS{ctrlWrEn}} & ctrlWrData[NUM_PATHS-1:0];
  assign fire  = tokQ & avail & ~{NUM_PATHS{gmaskQ}} & ~agree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gmaskQ <= 1'b0;
    else if (ctrlWrEn) gmaskQ <= ctrlWrData[GMASK_BIT];
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tokQ[p] <= 1'b1;
        irqQ[p] <= 1'b0;
      end else if (agree[p]) begin
        tokQ[p] <= 1'b1;
        irqQ[p] <= 1'b0;
      end else if (fire[p]) begin
        tokQ[p] <= 1'b0;
        irqQ[p] <= 1'b1;
      end
    end

    // R6: a rise consumes an armed token and needs an eligible line.
    assert_rise_needs_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irqQ[p]) |-> $past(tokQ[p]) && $past(avail[p]) && !tokQ[p]);

    // R9: nothing rises while the global mask is set.
    assert_gmask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gmaskQ |=> !$rose(irqQ[p]));

    // R8: an agreement drops the output and re-arms the token.
    assert_agree_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      agree[p] |=> !irqQ[p] && tokQ[p]);

    // R7: a raised output holds until its agreement arrives.
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irqQ[p] && !agree[p] |=> irqQ[p]);
  end

  assign strobe.latchNorm = fire[0];
  assign strobe.latchFast = fire[1];
  assign normIrq = irqQ[0];
  assign fastIrq = irqQ[1];
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_BANKS      = 3,
  parameter int LINES_PER_BANK = 32,
  parameter int PRIO_W         = 5
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]            pendVec,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]            maskVec,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]            fastSel,
  input  logic [NUM_BANKS*LINES_PER_BANK*PRIO_W-1:0]     prioFlat,
  input  logic                                           ctrlWrEn,
  input  logic [2:0]                                     ctrlWrData,
  output logic                                           normIrq,
  output logic                                           fastIrq,
  output logic [$clog2(NUM_BANKS*LINES_PER_BANK)-1:0]    normCode,
  output logic [$clog2(NUM_BANKS*LINES_PER_BANK)-1:0]    fastCode
);
  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;
  localparam int CODE_W    = $clog2(NUM_LINES);

  arbStrobe_t strobe;
  logic       normAvail;
  logic       fastAvail;

  prio_irq_datapath #(
    .NUM_LINES(NUM_LINES),
    .PRIO_W   (PRIO_W),
    .CODE_W   (CODE_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .pendVec  (pendVec),
    .maskVec  (maskVec),
    .fastSel  (fastSel),
    .prioFlat (prioFlat),
    .strobe   (strobe),
    .normAvail(normAvail),
    .fastAvail(fastAvail),
    .normCode (normCode),
    .fastCode (fastCode)
  );

  prio_irq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .normAvail (normAvail),
    .fastAvail (fastAvail),
    .strobe    (strobe),
    .normIrq   (normIrq),
    .fastIrq   (fastIrq)
  );
endmodule

// File: tb/prio_irq_arbiter_bench.sv
`timescale 1ns/1ps
module prio_irq_arbiter_bench;
  localparam int NL = 96;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pend = '0;
  logic [NL-1:0] mask = '0;
  logic [NL-1:0] fast = '0;
  logic [NL*PW-1:0] prio = '0;
  logic          ctrlWrEn = 1'b0;
  logic [2:0]    ctrlWrData = '0;
  logic          normIrq, fastIrq;
  logic [6:0]    normCode, fastCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_arbiter u_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .pendVec(pend), .maskVec(mask), .fastSel(fast),
    .prioFlat(prio), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .normIrq(normIrq), .fastIrq(fastIrq), .normCode(normCode), .fastCode(fastCode)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setLine(int line, int p, bit isFast);
    pend[line] = 1'b1;
    fast[line] = isFast;
    prio[line*PW +: PW] = p[PW-1:0];
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCtrl(logic [2:0] d);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(posedge clk);
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic quiesce();
    @(negedge clk);
    pend = '0; mask = '0; fast = '0; prio = '0;
    repeat (2) @(posedge clk);
    writeCtrl(3'b011);
    settle();
  endtask

  task automatic testReset();
    chk("R10", "normIrq after reset", normIrq, 0);
    chk("R10", "fastIrq after reset", fastIrq, 0);
    chk("R10", "normCode after reset", normCode, 0);
    chk("R10", "fastCode after reset", fastCode, 0);
    settle();
    chk("R10", "idle normIrq", normIrq, 0);
  endtask

  task automatic testSingleNormal();
    setLine(5, 3, 1'b0);
    settle();
    chk("R6", "normIrq single line", normIrq, 1);
    chk("R6", "normCode single line", normCode, 5);
    chk("R2", "fastIrq stays low for normal line", fastIrq, 0);
    quiesce();
  endtask

  task automatic testMasked();
    setLine(7, 0, 1'b0);
    setLine(8, 0, 1'b1);
    mask[7] = 1'b1; mask[8] = 1'b1;
    settle(); settle();
    chk("R1", "masked normal line ignored", normIrq, 0);
    chk("R2", "masked fast line ignored", fastIrq, 0);
    mask = '0;
    settle();
    chk("R1", "unmasked normal fires", normIrq, 1);
    chk("R1", "unmasked normal code", normCode, 7);
    chk("R2", "unmasked fast fires", fastIrq, 1);
    chk("R2", "unmasked fast code", fastCode, 8);
    quiesce();
  endtask

  task automatic testFastBank();
    setLine(40, 6, 1'b1);
    settle();
    chk("R2", "fast line fires", fastIrq, 1);
    chk("R5", "bank1 bit8 code", fastCode, 40);
    chk("R2", "normal path ignores fast line", normIrq, 0);
    quiesce();
  endtask

  task automatic testPriority();
    setLine(10, 4, 1'b0);
    setLine(70, 2, 1'b0);
    setLine(90, 9, 1'b0);
    settle();
    chk("R3", "lowest value wins", normCode, 70);
    quiesce();
    setLine(3, 0, 1'b0);
    setLine(95, 1, 1'b0);
    settle();
    chk("R3", "priority 0 beats higher line", normCode, 3);
    quiesce();
  endtask

  task automatic testTieAndHold();
    setLine(0, 31, 1'b0);
    setLine(95, 31, 1'b0);
    settle();
    chk("R5", "top line code", normCode, 95);
    quiesce();
    setLine(2, 5, 1'b0);
    setLine(33, 5, 1'b0);
    setLine(64, 5, 1'b0);
    settle();
    chk("R4", "tie goes to highest line", normCode, 64);
    pend = '0;
    setLine(1, 0, 1'b0);
    settle();
    chk("R7", "output held", normIrq, 1);
    chk("R7", "code frozen", normCode, 64);
    writeCtrl(3'b001);
    chk("R8", "agreement drops output", normIrq, 0);
    @(posedge clk); @(negedge clk);
    chk("R8", "re-fire after agreement", normIrq, 1);
    chk("R8", "new winner after agreement", normCode, 1);
    writeCtrl(3'b010);
    chk("R8", "zero agreement bit leaves output", normIrq, 1);
    chk("R8", "zero agreement bit leaves code", normCode, 1);
    quiesce();
  endtask

  task automatic testGlobalMask();
    writeCtrl(3'b100);
    setLine(12, 2, 1'b0);
    settle(); settle();
    chk("R9", "global mask blocks", normIrq, 0);
    writeCtrl(3'b000);
    chk("R9", "not yet fired at unmask edge", normIrq, 0);
    @(posedge clk); @(negedge clk);
    chk("R9", "fires after unmask", normIrq, 1);
    chk("R9", "code after unmask", normCode, 12);
    quiesce();
  endtask

  task automatic testIndependence();
    setLine(20, 4, 1'b0);
    setLine(50, 4, 1'b1);
    settle();
    chk("R11", "normal fired", normIrq, 1);
    chk("R11", "fast fired", fastIrq, 1);
    writeCtrl(3'b001);
    chk("R11", "fast unaffected by normal agreement", fastIrq, 1);
    chk("R11", "fast code unaffected", fastCode, 50);
    chk("R8", "normal dropped", normIrq, 0);
    @(posedge clk); @(negedge clk);
    chk("R11", "normal code after re-fire", normCode, 20);
    quiesce();
    chk("R8", "quiet after agreeing both", normIrq + fastIrq, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testSingleNormal();
    testMasked();
    testFastBank();
    testPriority();
    testTieAndHold();
    testGlobalMask();
    testIndependence();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule